// File: doc/BRIEF.md
# Swizzled Write-Masked Vector Adder

This block is the execution slice of a four-lane register machine. It owns a file of 32 registers, each 96 bits wide and split into four 24-bit channels named a, b, c and d. One instruction names two source registers and a destination. It also carries an independent channel selector for each source and a per-channel write mask for the destination.

Each source is reordered lane by lane through its selector. The two reordered operands are added channel by channel with a 24-bit wrapping adder. Only the destination channels enabled by the mask are written. The same adder serves plain signed integers and signed 7.16 fixed-point values, because both operands share the binary point.

A debug port reads any register combinationally and can load a whole register. It is the way registers are seeded and inspected. Per-lane signed overflow flags are reported one cycle after an issue.

Top module: `vec_swz_add`

## Requirements
- R1: The file holds 32 registers of 96 bits. Channel a is bits 23:0, b is bits 47:24, c is bits 71:48 and d is bits 95:72. `dbg_rdata` shows register `dbg_idx` combinationally.
- R2: Lane i of a reordered source takes the source channel coded in selector bits [2i+1:2i]. The codes are 0 for a, 1 for b, 2 for c and 3 for d.
- R3: Lane i of the result is lane i of reordered source A plus lane i of reordered source B, taken modulo 2^24.
- R4: Flag bit i of `ovf_flags` is set when the two lane-i operands have equal sign bits and the sign of the sum differs from them. The flag appears in the cycle after the issuing clock edge.
- R5: Mask bit i (0 for a through 3 for d) enables writing lane i. Destination channels whose bit is clear keep their old value, and an all-zero mask writes nothing.
- R6: Flags of lanes whose mask bit is clear read as zero.
- R7: When `issue_valid` is low at a clock edge, `ovf_flags` reads zero after that edge.
- R8: `rst_n` low at a clock edge clears every register and every flag.
- R9: The write commits at the clock edge that samples `issue_valid` high. Source reads in that cycle see the old contents, also when a source equals the destination.
- R10: `dbg_we` high at an edge loads `dbg_wdata` into register `dbg_idx`. If an instruction writes the same register at the same edge, its masked channels take precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction strobe |
| dst_idx | input | 5 | Destination register |
| src_a_idx | input | 5 | First source register |
| src_b_idx | input | 5 | Second source register |
| swz_a | input | 8 | Lane selector for first source |
| swz_b | input | 8 | Lane selector for second source |
| wmask | input | 4 | Destination channel write mask |
| dbg_idx | input | 5 | Debug register index |
| dbg_we | input | 1 | Debug whole-register load |
| dbg_wdata | input | 96 | Debug load data |
| dbg_rdata | output | 96 | Debug read data |
| ovf_flags | output | 4 | Per-lane overflow flags of the last issue |

## Verification
Inputs change on the falling edge, so each issue is sampled at the next rising edge. The destination contents and the overflow flags both become due right after that edge. The bench therefore samples them at the following falling edge, with `dbg_idx` already pointing at the destination.

A cycle without an issue is checked at the falling edge after the idle rising edge, where the flags must have returned to zero. Reset clearing is read one falling edge after the reset edge. The final sweep compares every register against the bench's model, which shows that unmasked channels and unnamed registers stayed untouched.

// File: rtl/vsa_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the swizzled vector adder.
// Assumes channel codes are dense from 0 upward in lane order.
package vsa_pkg;
    typedef enum logic [1:0] {
        CH_A = 2'd0,
        CH_B = 2'd1,
        CH_C = 2'd2,
        CH_D = 2'd3
    } chan_e;

    // Signed overflow of a wrapping add from the three sign bits.
    function automatic logic add_ovf(input logic sa, input logic sb, input logic ss);
        return (sa == sb) && (ss != sa);
    endfunction
endpackage

// File: rtl/vsa_swizzle.sv
`timescale 1ns/1ps
// Lane reorder: each output lane picks one input channel by its selector field.
// Assumes LANES is a power of two so every selector code names a channel.
module vsa_swizzle #(
    parameter int LANES = 4,
    parameter int CH_W  = 24,
    parameter int SEL_W = $clog2(LANES)
) (
    input  logic [LANES*CH_W-1:0]  src,
    input  logic [LANES*SEL_W-1:0] sel,
    output logic [LANES*CH_W-1:0]  dst
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0] code;
        assign code = sel[i*SEL_W +: SEL_W];
        // Multiplexer choosing the source channel for lane i.
        always_comb begin
            dst[i*CH_W +: CH_W] = '0;
            for (int c = 0; c < LANES; c++) begin
                if (code == SEL_W'(c)) dst[i*CH_W +: CH_W] = src[c*CH_W +: CH_W];
            end
        end
    end
endmodule

// File: rtl/vsa_lane_add.sv
`timescale 1ns/1ps
// One lane of the adder: two's complement wrap-around sum with a signed overflow flag.
// Assumes both operands share the same binary point (integer or fixed point).
module vsa_lane_add #(
    parameter int CH_W = 24
) (
    input  logic [CH_W-1:0] op_a,
    input  logic [CH_W-1:0] op_b,
    output logic [CH_W-1:0] sum,
    output logic            ovf
);
    import vsa_pkg::*;
    // Wrapping sum and its sign-based overflow detect.
    always_comb begin
        sum = op_a + op_b;
        ovf = add_ovf(op_a[CH_W-1], op_b[CH_W-1], sum[CH_W-1]);
    end
endmodule

// File: rtl/vsa_regfile.sv
`timescale 1ns/1ps
// Register file: three combinational read ports, one masked lane write and one whole-register load.
// Assumes the lane write is issued after the load in program order, so it wins on a clash.
module vsa_regfile #(
    parameter int NUM_REGS = 32,
    parameter int LANES    = 4,
    parameter int CH_W     = 24,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int REG_W   = LANES * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_a_idx,
    input  logic [ADDR_W-1:0] rd_b_idx,
    input  logic [ADDR_W-1:0] rd_d_idx,
    output logic [REG_W-1:0]  rd_a_data,
    output logic [REG_W-1:0]  rd_b_data,
    output logic [REG_W-1:0]  rd_d_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_idx,
    input  logic [REG_W-1:0]  ld_data
);
    logic [REG_W-1:0] mem [NUM_REGS];

    // Combinational reads of the current contents.
    always_comb begin
        rd_a_data = mem[rd_a_idx];
        rd_b_data = mem[rd_b_idx];
        rd_d_data = mem[rd_d_idx];
    end

    // Reset clear, debug load, then the masked lane write (the last write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
        end else begin
            if (ld_en) mem[ld_idx] <= ld_data;
            if (wr_en) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_mask[l]) mem[wr_idx][l*CH_W +: CH_W] <= wr_data[l*CH_W +: CH_W];
                end
            end
        end
    end
endmodule

// File: rtl/vec_swz_add.sv
`timescale 1ns/1ps
// Top: reorders two source registers, adds them lane by lane and writes the masked lanes back.
// Assumes one instruction per cycle and no hazard logic beyond read-old-on-write.
module vec_swz_add #(
    parameter int NUM_REGS = 32,
    parameter int LANES    = 4,
    parameter int CH_W     = 24,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int SEL_W   = $clog2(LANES),
    localparam int REG_W   = LANES * CH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_valid,
    input  logic [ADDR_W-1:0]      dst_idx,
    input  logic [ADDR_W-1:0]      src_a_idx,
    input  logic [ADDR_W-1:0]      src_b_idx,
    input  logic [LANES*SEL_W-1:0] swz_a,
    input  logic [LANES*SEL_W-1:0] swz_b,
    input  logic [LANES-1:0]       wmask,
    input  logic [ADDR_W-1:0]      dbg_idx,
    input  logic                   dbg_we,
    input  logic [REG_W-1:0]       dbg_wdata,
    output logic [REG_W-1:0]       dbg_rdata,
    output logic [LANES-1:0]       ovf_flags
);
    logic [REG_W-1:0] raw_a, raw_b, opnd_a, opnd_b, sums;
    logic [LANES-1:0] lane_ovf;
    logic [LANES-1:0] ovf_q;

    vsa_regfile #(.NUM_REGS(NUM_REGS), .LANES(LANES), .CH_W(CH_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (src_a_idx),
        .rd_b_idx  (src_b_idx),
        .rd_d_idx  (dbg_idx),
        .rd_a_data (raw_a),
        .rd_b_data (raw_b),
        .rd_d_data (dbg_rdata),
        .wr_en     (issue_valid),
        .wr_idx    (dst_idx),
        .wr_mask   (wmask),
        .wr_data   (sums),
        .ld_en     (dbg_we),
        .ld_idx    (dbg_idx),
        .ld_data   (dbg_wdata)
    );

    vsa_swizzle #(.LANES(LANES), .CH_W(CH_W), .SEL_W(SEL_W)) u_swz_a (
        .src (raw_a), .sel (swz_a), .dst (opnd_a)
    );

    vsa_swizzle #(.LANES(LANES), .CH_W(CH_W), .SEL_W(SEL_W)) u_swz_b (
        .src (raw_b), .sel (swz_b), .dst (opnd_b)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_add
        vsa_lane_add #(.CH_W(CH_W)) u_add (
            .op_a (opnd_a[i*CH_W +: CH_W]),
            .op_b (opnd_b[i*CH_W +: CH_W]),
            .sum  (sums[i*CH_W +: CH_W]),
            .ovf  (lane_ovf[i])
        );
    end

    // Capture overflow flags of written lanes; clear them on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)           ovf_q <= '0;
        else if (issue_valid) ovf_q <= lane_ovf & wmask;
        else                  ovf_q <= '0;
    end

    assign ovf_flags = ovf_q;
endmodule

// File: rtl/vsa_checker.sv
`timescale 1ns/1ps
// Protocol checker for vec_swz_add, attached by bind; observes ports only.
module vsa_checker #(
    parameter int LANES  = 4,
    parameter int REG_W  = 96,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [LANES-1:0]  wmask,
    input logic [ADDR_W-1:0] dbg_idx,
    input logic              dbg_we,
    input logic [REG_W-1:0]  dbg_rdata,
    input logic [LANES-1:0]  ovf_flags
);
    logic past_ok = 1'b0;
    // Marks that at least one edge has been seen, so $past is meaningful.
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_idle_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> ovf_flags == '0);

    assert_masked_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> (ovf_flags & ~$past(wmask)) == '0);

    assert_no_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(rst_n) && !$past(dbg_we) &&
        (!$past(issue_valid) || $past(wmask) == '0) && dbg_idx == $past(dbg_idx)
        |-> dbg_rdata == $past(dbg_rdata));

    assert_reset_clear_R8: assert property (@(posedge clk)
        past_ok && $past(!rst_n) |-> (dbg_rdata == '0 && ovf_flags == '0));
endmodule

bind vec_swz_add vsa_checker #(.LANES(LANES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .wmask       (wmask),
    .dbg_idx     (dbg_idx),
    .dbg_we      (dbg_we),
    .dbg_rdata   (dbg_rdata),
    .ovf_flags   (ovf_flags)
);

// File: tb/vec_swz_add_bench.sv
`timescale 1ns/1ps
// Bench: seeds the file, sweeps swizzles, masks and operands, and checks against an arithmetic model.
module vec_swz_add_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [4:0]  dst_idx = '0, src_a_idx = '0, src_b_idx = '0, dbg_idx = '0;
    logic [7:0]  swz_a = '0, swz_b = '0;
    logic [3:0]  wmask = '0;
    logic        dbg_we = 1'b0;
    logic [95:0] dbg_wdata = '0;
    logic [95:0] dbg_rdata;
    logic [3:0]  ovf_flags;

    int checks = 0;
    int errors = 0;
    logic [95:0] model [32];

    always #5 clk = ~clk;

    vec_swz_add u_vec_swz_add (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .dst_idx(dst_idx),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .swz_a(swz_a), .swz_b(swz_b),
        .wmask(wmask), .dbg_idx(dbg_idx), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .ovf_flags(ovf_flags)
    );

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] seed_val(input int r, input int l);
        logic [23:0] pat [8] = '{24'h7FFFFF, 24'h800000, 24'h000001, 24'hFFFFFF,
                                  24'h400000, 24'hC00000, 24'h123456, 24'h000000};
        if (r < 16) return pat[(r + l*3) % 8];
        return 24'(r * (l + 1) * 32'h01F3A7 + r);
    endfunction

    // Debug load of a whole register (R10 path), applied on the next rising edge.
    task automatic load(input int r, input logic [95:0] v);
        dbg_we = 1'b1; dbg_idx = 5'(r); dbg_wdata = v;
        @(negedge clk);
        dbg_we = 1'b0;
        model[r] = v;
    endtask

    // Issue one instruction and check the flags and the destination one edge later.
    task automatic issue(input int d, input int sa, input int sb,
                         input logic [7:0] za, input logic [7:0] zb, input logic [3:0] m);
        logic [95:0] exp_reg;
        logic [3:0]  exp_ovf;
        exp_reg = model[d];
        exp_ovf = '0;
        for (int l = 0; l < 4; l++) begin
            logic [23:0] a, b, s;
            a = model[sa][za[2*l +: 2]*24 +: 24];   // R2 selector decode
            b = model[sb][zb[2*l +: 2]*24 +: 24];
            s = a + b;                              // R3 wrap
            if (m[l]) begin
                exp_reg[l*24 +: 24] = s;            // R5, R9 old-value read
                exp_ovf[l] = (a[23] == b[23]) && (s[23] != a[23]);  // R4, R6
            end
        end
        issue_valid = 1'b1; dst_idx = 5'(d); src_a_idx = 5'(sa); src_b_idx = 5'(sb);
        swz_a = za; swz_b = zb; wmask = m; dbg_idx = 5'(d);
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R4/R6 flags", 96'(ovf_flags), 96'(exp_ovf));
        chk("R3/R5/R9 dest", dbg_rdata, exp_reg);
        model[d] = exp_reg;
    endtask

    task automatic sweep_all(input string req);
        for (int r = 0; r < 32; r++) begin
            dbg_idx = 5'(r);
            #1;
            chk(req, dbg_rdata, model[r]);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 32; r++) model[r] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R8 and R1: every register reads zero after reset.
        sweep_all("R8 reset clear");
        chk("R8 flags", 96'(ovf_flags), 96'(0));

        // Seed all registers through the debug load and read them back (R1).
        for (int r = 0; r < 32; r++) begin
            logic [95:0] v;
            for (int l = 0; l < 4; l++) v[l*24 +: 24] = seed_val(r, l);
            load(r, v);
        end
        sweep_all("R1 load readback");

        // R2: identity and channel-broadcast swizzles, with source B held at zero.
        load(31, '0);
        issue(30, 5, 31, 8'hE4, 8'h00, 4'hF);
        issue(29, 6, 31, 8'h00, 8'h00, 4'hF);
        issue(28, 6, 31, 8'hFF, 8'h00, 4'hF);
        issue(27, 7, 31, 8'h1B, 8'h00, 4'hF);

        // Near-exhaustive sweep: all 256 selectors on A, all 16 masks, varied registers.
        for (int k = 0; k < 512; k++) begin
            issue((k*11) % 32, k % 32, (k*7 + 3) % 32, 8'(k), 8'(k*37 + 11), 4'(k*5 + 3));
            if (k % 16 == 15) begin
                // R7: an idle edge clears the flags.
                @(negedge clk);
                chk("R7 idle flags", 96'(ovf_flags), 96'(0));
            end
        end

        // R9: source equals destination, so the old value is read.
        issue(12, 12, 12, 8'hE4, 8'hE4, 4'hF);
        issue(13, 13, 14, 8'h4E, 8'hB1, 4'b0101);
        // R5: a zero mask leaves the destination and the flags untouched.
        issue(0, 0, 1, 8'hAA, 8'h55, 4'h0);

        // R10: a debug load and an instruction hit the same register at one edge.
        begin
            logic [95:0] ld, exp_reg;
            logic [23:0] s;
            ld = 96'hABCDEF_123456_0F0F0F_777777;
            s = model[3][23:0] + model[4][23:0];
            exp_reg = ld;
            exp_reg[47:24] = s;
            issue_valid = 1'b1; dst_idx = 5'd9; src_a_idx = 5'd3; src_b_idx = 5'd4;
            swz_a = 8'h00; swz_b = 8'h00; wmask = 4'b0010;
            dbg_we = 1'b1; dbg_idx = 5'd9; dbg_wdata = ld;
            @(negedge clk);
            issue_valid = 1'b0; dbg_we = 1'b0;
            chk("R10 load vs write", dbg_rdata, exp_reg);
            model[9] = exp_reg;
        end

        // R5: registers and channels that were not written hold the model values.
        sweep_all("R5 untouched state");

        // R8: a reset in mid-run clears everything again.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) model[r] = '0;
        sweep_all("R8 mid-run reset");
        chk("R8 flags after reset", 96'(ovf_flags), 96'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule